// File: doc/BRIEF.md
# Multi-lane bonding status controller

This block coordinates alignment and elasticity-buffer management across a group of bonded receive lanes, and lets several devices be chained so that they act in lockstep. Every lane reports when it has valid framing and when it has seen the bonding sequence. A small state machine per lane decides when that lane may align its buffer pipeline. An inhibit input chooses between two policies: all lanes wait for each other, or each lane proceeds on its own. In both policies the selected reference lane must be part of the group before any lane aligns.

One device is the master and the others are slaves. The master picks a reference lane with a select input and encodes that lane's buffer event into a 2-bit status word, one word per receive clock. The master drives the word onto shared lines only while it is in master mode, the receive path runs from the reference clock and all of its lanes are aligned. At all other times the lines are released and read as the pulled-up value 11. Every device, master included, runs the same command state machine on the word it sees on the lines. An insert or delete command is therefore applied on the same cycle on every lane of every device. Each device also pulls a shared open-drain all-bonded line low while any of its own lanes is not aligned.

States of the per-lane machine: HUNT (no framing), FRAMED (framing, no bonding sequence yet), SEEN (bonding sequence seen, waiting for permission) and ALIGNED. Transitions: HUNT to FRAMED when framing is present; FRAMED to SEEN on the bonding-sequence strobe; SEEN to ALIGNED when permission is granted; any state to HUNT when framing is lost. States of the encoder: RELEASED and DRIVING. It enters DRIVING when the drive condition holds and returns to RELEASED when it does not. States of the command machine: IDLE, INS_PEND and DEL_PEND. A 01 word moves it to INS_PEND and a 10 word moves it to DEL_PEND. A 00 word returns it to IDLE. Under an 11 word, a pending state fires its action and returns to IDLE on a cycle where every lane shows a framing character.

Top module: `bond_status_ctrl`

## Requirements
- R1: During and right after reset, lane_align_en, lane_insert, lane_delete and stat_oe are all 0, stat_out is 11, and bond_all_pd equals ref_clocked.
- R2: A lane with lane_framed low at a clock edge is in HUNT after that edge, with lane_align_en low. With framing present, HUNT moves to FRAMED. FRAMED moves to SEEN when lane_bond_seq is high. lane_align_en is high exactly in ALIGNED.
- R3: While bond_inhibit_n is 0, a lane in SEEN moves to ALIGNED only on an edge where every lane is in SEEN or ALIGNED.
- R4: While bond_inhibit_n is 1, a lane in SEEN moves to ALIGNED on the next edge, provided the reference lane is in SEEN or ALIGNED.
- R5: No lane moves to ALIGNED on an edge where the lane selected by ref_lane_sel is in HUNT or FRAMED.
- R6: stat_out is registered. After the edge that ends cycle t, it holds the code for the reference lane's strobes in cycle t: 00 if the sync strobe is high, else 10 if the delete strobe is high, else 01 if the insert strobe is high, else 11.
- R7: stat_oe is 1 after an edge exactly when, before that edge, master_sel_n was 0, ref_clocked was 1 and all lanes were ALIGNED. When stat_oe is 0, the shared lines read 11.
- R8: bond_all_pd is 1 exactly when ref_clocked is 1 and some lane is not ALIGNED. The wired-AND of all devices therefore drops right after the edge on which any lane loses framing.
- R9: A 01 word seen in cycle c arms an insert. lane_insert is then 1 on all lanes for one cycle, right after the first later cycle in which the word is 11 and every bit of lane_frame_char is 1.
- R10: A 10 word arms a delete in the same way, with lane_delete pulsing on all lanes.
- R11: A 00 word cancels a pending action. A new 01 or 10 word replaces the pending one, and no action fires in a cycle that carries a non-11 word. lane_insert and lane_delete are never 1 together.
- R12: A slave (master_sel_n = 1) ignores its own event strobes and acts on stat_in only. Its lane_insert and lane_delete match the master's on every cycle when both see the same lane inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel_n | input | 1 | 0 selects master mode, 1 selects slave mode |
| ref_clocked | input | 1 | Receive parallel path runs from the reference clock |
| ref_lane_sel | input | SEL_W | Reference lane index |
| bond_inhibit_n | input | 1 | 0 makes all lanes wait for each other before aligning |
| lane_framed | input | NUM_LANES | Per-lane valid framing |
| lane_bond_seq | input | NUM_LANES | Per-lane bonding sequence strobe |
| lane_frame_char | input | NUM_LANES | Per-lane framing character strobe |
| lane_sync_evt | input | NUM_LANES | Per-lane word-sync event strobe |
| lane_ins_evt | input | NUM_LANES | Per-lane buffer insert event strobe |
| lane_del_evt | input | NUM_LANES | Per-lane buffer delete event strobe |
| stat_in | input | 2 | Status word read from the shared lines |
| stat_out | output | 2 | Registered status word for the shared lines |
| stat_oe | output | 1 | Drive enable for stat_out |
| bond_all_pd | output | 1 | Pull-down enable for the shared all-bonded line |
| lane_align_en | output | NUM_LANES | Per-lane alignment permitted (ALIGNED) |
| lane_insert | output | NUM_LANES | Per-lane insert-one-character pulse |
| lane_delete | output | NUM_LANES | Per-lane drop-next-framing-character pulse |

## Verification
The bench builds one master and two slaves with the default NUM_LANES of 4 and SEL_W of 2. This makes the whole group small enough to bond and rebond many times in a run. Each of the four values of ref_lane_sel can be given a lane that is not yet a member, and staggered bonding sequences can be tried under both inhibit settings. With only four lanes, a cycle in which every lane shows a framing character is common. Insert, delete and cancel commands therefore fire often, and their all-lane, all-device timing is compared every cycle.

// File: rtl/bond_pkg.sv
package bond_pkg;

    typedef enum logic [1:0] {
        L_HUNT    = 2'd0,
        L_FRAMED  = 2'd1,
        L_SEEN    = 2'd2,
        L_ALIGNED = 2'd3
    } lane_st_e;

    typedef enum logic [1:0] {
        A_IDLE     = 2'd0,
        A_INS_PEND = 2'd1,
        A_DEL_PEND = 2'd2
    } apply_st_e;

    typedef enum logic {
        E_RELEASED = 1'b0,
        E_DRIVING  = 1'b1
    } enc_st_e;

    localparam int          CODE_W    = 2;
    localparam logic [1:0]  CODE_SYNC = 2'b00;
    localparam logic [1:0]  CODE_INS  = 2'b01;
    localparam logic [1:0]  CODE_DEL  = 2'b10;
    localparam logic [1:0]  CODE_NORM = 2'b11;

endpackage

// File: rtl/bond_lane_fsm.sv
module bond_lane_fsm
    import bond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic framed,
    input  logic bond_seq,
    input  logic align_perm,
    output logic seen,
    output logic aligned
);

    lane_st_e st_q;
    lane_st_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= L_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!framed) begin
            st_d = L_HUNT;
        end else begin
            unique case (st_q)
                L_HUNT:    st_d = L_FRAMED;
                L_FRAMED:  if (bond_seq) st_d = L_SEEN;
                L_SEEN:    if (align_perm) st_d = L_ALIGNED;
                L_ALIGNED: st_d = L_ALIGNED;
                default:   st_d = L_HUNT;
            endcase
        end
    end

    always_comb begin
        seen    = (st_q == L_SEEN) || (st_q == L_ALIGNED);
        aligned = (st_q == L_ALIGNED);
    end

    // R2
    lost_framing_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(framed) |-> (!seen && !aligned));

    // R2
    align_needs_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> ($past(seen) && $past(align_perm)));

endmodule

// File: rtl/bond_stat_enc.sv
module bond_stat_enc
    import bond_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int SEL_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_n,
    input  logic                 ref_clocked,
    input  logic                 all_aligned,
    input  logic [SEL_W-1:0]     ref_sel,
    input  logic [NUM_LANES-1:0] sync_evt,
    input  logic [NUM_LANES-1:0] ins_evt,
    input  logic [NUM_LANES-1:0] del_evt,
    output logic [CODE_W-1:0]    stat_q,
    output logic                 drive
);

    enc_st_e           st_q;
    enc_st_e           st_d;
    logic [CODE_W-1:0] code_d;
    logic              drive_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= E_RELEASED;
            stat_q <= CODE_NORM;
        end else begin
            st_q   <= st_d;
            stat_q <= code_d;
        end
    end

    always_comb begin
        drive_ok = !master_n && ref_clocked && all_aligned;
        st_d     = st_q;
        unique case (st_q)
            E_RELEASED: if (drive_ok)  st_d = E_DRIVING;
            E_DRIVING:  if (!drive_ok) st_d = E_RELEASED;
            default:    st_d = E_RELEASED;
        endcase
    end

    always_comb begin
        if (sync_evt[ref_sel]) begin
            code_d = CODE_SYNC;
        end else if (del_evt[ref_sel]) begin
            code_d = CODE_DEL;
        end else if (ins_evt[ref_sel]) begin
            code_d = CODE_INS;
        end else begin
            code_d = CODE_NORM;
        end
        drive = (st_q == E_DRIVING);
    end

    // R7
    drive_only_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> ($past(!master_n) && $past(ref_clocked) && $past(all_aligned)));

    // R6
    sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_evt[ref_sel]) |-> (stat_q == CODE_SYNC));

endmodule

// File: rtl/bond_cmd_apply.sv
module bond_cmd_apply
    import bond_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_W-1:0]    code,
    input  logic [NUM_LANES-1:0] frame_char,
    output logic [NUM_LANES-1:0] ins_pulse,
    output logic [NUM_LANES-1:0] del_pulse
);

    apply_st_e st_q;
    apply_st_e st_d;
    logic      ins_q;
    logic      del_q;
    logic      ins_d;
    logic      del_d;
    logic      fchar_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= A_IDLE;
            ins_q <= 1'b0;
            del_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ins_q <= ins_d;
            del_q <= del_d;
        end
    end

    always_comb begin
        fchar_all = &frame_char;
        st_d      = st_q;
        ins_d     = 1'b0;
        del_d     = 1'b0;
        unique case (code)
            CODE_SYNC: st_d = A_IDLE;
            CODE_INS:  st_d = A_INS_PEND;
            CODE_DEL:  st_d = A_DEL_PEND;
            default: begin
                unique case (st_q)
                    A_INS_PEND: begin
                        if (fchar_all) begin
                            ins_d = 1'b1;
                            st_d  = A_IDLE;
                        end
                    end
                    A_DEL_PEND: begin
                        if (fchar_all) begin
                            del_d = 1'b1;
                            st_d  = A_IDLE;
                        end
                    end
                    default: st_d = A_IDLE;
                endcase
            end
        endcase
    end

    always_comb begin
        ins_pulse = {NUM_LANES{ins_q}};
        del_pulse = {NUM_LANES{del_q}};
    end

    // R9
    ins_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ins_pulse) |-> ($past(st_q == A_INS_PEND) && $past(code == CODE_NORM) && $past(&frame_char)));

    // R10
    del_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|del_pulse) |-> ($past(st_q == A_DEL_PEND) && $past(code == CODE_NORM) && $past(&frame_char)));

    // R11
    no_ins_del_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|ins_pulse) && (|del_pulse)));

    // R9
    ins_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_pulse == '0) || (&ins_pulse));

endmodule

// File: rtl/bond_status_ctrl.sv
module bond_status_ctrl
    import bond_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_sel_n,
    input  logic                 ref_clocked,
    input  logic [SEL_W-1:0]     ref_lane_sel,
    input  logic                 bond_inhibit_n,
    input  logic [NUM_LANES-1:0] lane_framed,
    input  logic [NUM_LANES-1:0] lane_bond_seq,
    input  logic [NUM_LANES-1:0] lane_frame_char,
    input  logic [NUM_LANES-1:0] lane_sync_evt,
    input  logic [NUM_LANES-1:0] lane_ins_evt,
    input  logic [NUM_LANES-1:0] lane_del_evt,
    input  logic [1:0]           stat_in,
    output logic [1:0]           stat_out,
    output logic                 stat_oe,
    output logic                 bond_all_pd,
    output logic [NUM_LANES-1:0] lane_align_en,
    output logic [NUM_LANES-1:0] lane_insert,
    output logic [NUM_LANES-1:0] lane_delete
);

    logic [NUM_LANES-1:0] seen_vec;
    logic [NUM_LANES-1:0] aligned_vec;
    logic                 all_seen;
    logic                 all_aligned;
    logic                 ref_member;
    logic                 align_perm;
    logic [CODE_W-1:0]    enc_code;
    logic                 enc_drive;
    logic [CODE_W-1:0]    code_eff;

    always_comb begin
        all_seen    = &seen_vec;
        all_aligned = &aligned_vec;
        ref_member  = seen_vec[ref_lane_sel];
        align_perm  = ref_member && (bond_inhibit_n || all_seen);
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bond_lane_fsm u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .framed     (lane_framed[g]),
            .bond_seq   (lane_bond_seq[g]),
            .align_perm (align_perm),
            .seen       (seen_vec[g]),
            .aligned    (aligned_vec[g])
        );
    end

    bond_stat_enc #(
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W)
    ) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_n    (master_sel_n),
        .ref_clocked (ref_clocked),
        .all_aligned (all_aligned),
        .ref_sel     (ref_lane_sel),
        .sync_evt    (lane_sync_evt),
        .ins_evt     (lane_ins_evt),
        .del_evt     (lane_del_evt),
        .stat_q      (enc_code),
        .drive       (enc_drive)
    );

    always_comb begin
        if (!master_sel_n) begin
            code_eff = enc_drive ? enc_code : CODE_NORM;
        end else begin
            code_eff = stat_in;
        end
    end

    bond_cmd_apply #(
        .NUM_LANES (NUM_LANES)
    ) u_apply (
        .clk        (clk),
        .rst_n      (rst_n),
        .code       (code_eff),
        .frame_char (lane_frame_char),
        .ins_pulse  (lane_insert),
        .del_pulse  (lane_delete)
    );

    always_comb begin
        stat_out      = enc_code;
        stat_oe       = enc_drive;
        bond_all_pd   = ref_clocked && !all_aligned;
        lane_align_en = aligned_vec;
    end

    // R3
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(aligned_vec & ~$past(aligned_vec))) && $past(!bond_inhibit_n)) |-> $past(&seen_vec));

    // R5
    ref_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(aligned_vec & ~$past(aligned_vec))) |-> $past(seen_vec[ref_lane_sel]));

    // R8
    framing_loss_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!(&lane_framed)) && ref_clocked) |-> bond_all_pd);

    // R7
    released_not_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_sel_n) |-> !stat_oe);

endmodule

// File: tb/bond_status_ctrl_tb_top.sv
module bond_status_ctrl_tb_top;

    localparam int NL = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          refclk;
    logic          inh_n;
    logic [SW-1:0] rsel;
    logic [NL-1:0] fr, bs, fc, sy, ie, de, sy_s, ie_s, de_s;

    logic [1:0]    m_stat, s0_stat, s1_stat;
    logic          m_oe, s0_oe, s1_oe, m_pd, s0_pd, s1_pd;
    logic [NL-1:0] m_al, s0_al, s1_al, m_ins, s0_ins, s1_ins, m_del, s0_del, s1_del;
    logic [1:0]    bus;
    logic          bond_all;

    assign bus      = m_oe ? m_stat : 2'b11;
    assign bond_all = ~(m_pd | s0_pd | s1_pd);

    bond_status_ctrl #(.NUM_LANES(NL), .SEL_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_sel_n(1'b0), .ref_clocked(refclk),
        .ref_lane_sel(rsel), .bond_inhibit_n(inh_n), .lane_framed(fr),
        .lane_bond_seq(bs), .lane_frame_char(fc), .lane_sync_evt(sy),
        .lane_ins_evt(ie), .lane_del_evt(de), .stat_in(2'b00),
        .stat_out(m_stat), .stat_oe(m_oe), .bond_all_pd(m_pd),
        .lane_align_en(m_al), .lane_insert(m_ins), .lane_delete(m_del));

    bond_status_ctrl #(.NUM_LANES(NL), .SEL_W(SW)) slv0_i (
        .clk(clk), .rst_n(rst_n), .master_sel_n(1'b1), .ref_clocked(refclk),
        .ref_lane_sel(rsel), .bond_inhibit_n(inh_n), .lane_framed(fr),
        .lane_bond_seq(bs), .lane_frame_char(fc), .lane_sync_evt(sy_s),
        .lane_ins_evt(ie_s), .lane_del_evt(de_s), .stat_in(bus),
        .stat_out(s0_stat), .stat_oe(s0_oe), .bond_all_pd(s0_pd),
        .lane_align_en(s0_al), .lane_insert(s0_ins), .lane_delete(s0_del));

    bond_status_ctrl #(.NUM_LANES(NL), .SEL_W(SW)) slv1_i (
        .clk(clk), .rst_n(rst_n), .master_sel_n(1'b1), .ref_clocked(refclk),
        .ref_lane_sel(rsel), .bond_inhibit_n(inh_n), .lane_framed(fr),
        .lane_bond_seq(bs), .lane_frame_char(fc), .lane_sync_evt(ie_s),
        .lane_ins_evt(de_s), .lane_del_evt(sy_s), .stat_in(bus),
        .stat_out(s1_stat), .stat_oe(s1_oe), .bond_all_pd(s1_pd),
        .lane_align_en(s1_al), .lane_insert(s1_ins), .lane_delete(s1_del));

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state: lane 0 HUNT, 1 FRAMED, 2 SEEN, 3 ALIGNED
    int         ml[NL];
    logic [1:0] mq;
    bit         moe;
    int         ap;
    bit         mins, mdel;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] enc_code(input logic s, input logic d, input logic i);
        if (s) return 2'b00;
        if (d) return 2'b10;
        if (i) return 2'b01;
        return 2'b11;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NL; i++) ml[i] = 0;
        mq = 2'b11; moe = 0; ap = 0; mins = 0; mdel = 0;
    endtask

    task automatic model_step();
        int nml[NL];
        bit allal, allseen, perm, nins, ndel;
        int nap;
        logic [1:0] code;
        allal = 1; allseen = 1;
        for (int i = 0; i < NL; i++) begin
            if (ml[i] != 3) allal = 0;
            if (ml[i] < 2) allseen = 0;
        end
        perm = (ml[rsel] >= 2) && (inh_n || allseen);
        for (int i = 0; i < NL; i++) begin
            if (!fr[i]) nml[i] = 0;
            else case (ml[i])
                0: nml[i] = 1;
                1: nml[i] = bs[i] ? 2 : 1;
                2: nml[i] = perm ? 3 : 2;
                default: nml[i] = 3;
            endcase
        end
        code = moe ? mq : 2'b11;
        nins = 0; ndel = 0; nap = ap;
        case (code)
            2'b00: nap = 0;
            2'b01: nap = 1;
            2'b10: nap = 2;
            default: begin
                if (ap == 1 && fc == 4'hf) begin nins = 1; nap = 0; end
                else if (ap == 2 && fc == 4'hf) begin ndel = 1; nap = 0; end
            end
        endcase
        moe  = refclk && allal;
        mq   = enc_code(sy[rsel], de[rsel], ie[rsel]);
        ap   = nap; mins = nins; mdel = ndel;
        for (int i = 0; i < NL; i++) ml[i] = nml[i];
    endtask

    task automatic compare();
        bit allal;
        logic [NL-1:0] exp_al;
        allal = 1;
        for (int i = 0; i < NL; i++) begin
            exp_al[i] = (ml[i] == 3);
            if (ml[i] != 3) allal = 0;
        end
        chk("R2 R3 R4 R5 master lane_align_en", 8'(m_al), 8'(exp_al));
        chk("R12 slave0 lane_align_en", 8'(s0_al), 8'(exp_al));
        chk("R6 stat_out", 8'(m_stat), 8'(mq));
        chk("R7 stat_oe", 8'(m_oe), 8'(moe));
        chk("R7 slave stat_oe", 8'(s0_oe | s1_oe), 8'h0);
        chk("R8 master bond_all_pd", 8'(m_pd), 8'(refclk && !allal));
        chk("R8 slave bond_all_pd", 8'(s1_pd), 8'(refclk && !allal));
        chk("R8 wired-AND bond_all", 8'(bond_all), 8'(!(refclk && !allal)));
        chk("R9 R11 master lane_insert", 8'(m_ins), mins ? 8'h0f : 8'h00);
        chk("R10 R11 master lane_delete", 8'(m_del), mdel ? 8'h0f : 8'h00);
        chk("R12 slave0 lane_insert", 8'(s0_ins), mins ? 8'h0f : 8'h00);
        chk("R12 slave1 lane_delete", 8'(s1_del), mdel ? 8'h0f : 8'h00);
        chk("R12 slave1 lane_insert", 8'(s1_ins), mins ? 8'h0f : 8'h00);
        chk("R12 slave0 lane_delete", 8'(s0_del), mdel ? 8'h0f : 8'h00);
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic quiet();
        bs = '0; fc = '0; sy = '0; ie = '0; de = '0;
    endtask

    task automatic bond_up(input logic [SW-1:0] r);
        rsel = r; fr = 4'hf; inh_n = 1'b1; quiet();
        step();
        bs = 4'hf; step();
        bs = '0; step(); step(); step();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_b0d1));
        rst_n = 1'b0; refclk = 1'b1; inh_n = 1'b1; rsel = '0;
        fr = '0; quiet(); sy_s = '0; ie_s = '0; de_s = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset lane_align_en", 8'(m_al), 8'h0);
        chk("R1 reset stat_oe", 8'(m_oe), 8'h0);
        chk("R1 reset stat_out", 8'(m_stat), 8'h3);
        chk("R1 reset pulses", 8'(m_ins | m_del), 8'h0);
        chk("R1 reset bond_all_pd", 8'(m_pd), 8'(refclk));
        @(negedge clk);
        rst_n = 1'b1;

        // R3: staggered bonding sequences with inhibit low, reference lane 0
        inh_n = 1'b0; rsel = 2'd0; fr = 4'hf; step();
        bs = 4'b0001; step();
        bs = 4'b0010; step();
        bs = 4'b0100; step(); step();
        chk("R3 hold until all seen", 8'(m_al), 8'h0);
        bs = 4'b1000; step();
        bs = '0; step(); step();

        // R4 R5: inhibit high, reference lane 2 not yet a member
        fr = 4'h0; step();
        fr = 4'hf; inh_n = 1'b1; rsel = 2'd2; step();
        bs = 4'b0001; step();
        bs = '0; step(); step();
        chk("R5 ref lane not member", 8'(m_al), 8'h0);
        bs = 4'b0100; step(); bs = '0; step(); step();
        bs = 4'b1010; step(); bs = '0; step(); step();

        // R9: insert with a framing character in the code cycle, then a partial one
        bond_up(2'd1);
        ie = 4'b0010; step();
        ie = '0; fc = 4'hf; step();
        fc = 4'b0011; step();
        fc = 4'hf; step();
        fc = '0; step();

        // R10 R11: delete cancelled by sync, then delete replaced by insert, then delete fires
        de = 4'b0010; step(); de = '0; step();
        sy = 4'b0010; step(); sy = '0; fc = 4'hf; step(); step(); fc = '0;
        de = 4'b0010; step(); de = '0; ie = 4'b0010; step(); ie = '0; fc = 4'hf; step(); step();
        de = 4'b0010; ie = 4'b0010; fc = '0; step(); de = '0; ie = '0; fc = 4'hf; step(); step();

        // R7 R8: reference clock off, then a lane loses framing
        refclk = 1'b0; quiet(); step(); step();
        refclk = 1'b1; step(); step();
        fr = 4'b1011; step(); step();
        fr = 4'hf; step();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 0) rsel = SW'($urandom_range(0, NL - 1));
            if (n % 500 == 0) inh_n = 1'($urandom_range(0, 1));
            if (n % 700 == 0) refclk = ($urandom_range(0, 3) != 0);
            for (int i = 0; i < NL; i++) begin
                fr[i] = ($urandom_range(0, 299) != 0) || (n % 1000 < 200);
                bs[i] = ($urandom_range(0, 3) == 0);
                sy[i] = ($urandom_range(0, 19) == 0);
                ie[i] = ($urandom_range(0, 5) == 0);
                de[i] = ($urandom_range(0, 5) == 0);
                sy_s[i] = ($urandom_range(0, 2) == 0);
                ie_s[i] = ($urandom_range(0, 2) == 0);
                de_s[i] = ($urandom_range(0, 2) == 0);
            end
            fc = ($urandom_range(0, 2) == 0) ? 4'hf : NL'($urandom);
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule